// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds the return addresses of a processor core in a small on-chip stack. Subroutine calls and interrupt entries push a return address, returns pop it, and two instruction strobes give software its own push (which stores the current program counter) and its own pop (which only discards the top entry). The pointer selects the top entry and can be loaded directly. The top entry can be read and changed one byte at a time, so software can move return addresses to and from a stack in data memory.

Position 0 is the empty position and always reads as zero. When the pointer reaches the highest position, a full flag is set. A pop with nothing left on the stack sets an underflow flag. A configuration input decides what these conditions do. With the input low, the stack stops at the top and ignores further pushes. With the input high, the block also sends a one-cycle reset request to the chip's reset generator. Both flags survive the device reset that follows, and only a power-on reset or an explicit clear removes them.

Top module: `ras_stack`

## Requirements
- R1: While `rst_n` or `por_n` is low, `sp` is 0 and `rst_req` is 0. While `por_n` is low, `full` and `unf` are also 0.
- R2: A push below the top position increments `sp` on the next clock edge and stores the pushed value in the new top entry. A call push stores `call_addr` and an instruction push stores `pc_now`. If both push strobes are high, `call_addr` is stored.
- R3: During a pop cycle, `ret_addr` shows the top entry. A return pop and an instruction pop each decrement `sp` by one on the clock edge.
- R4: A push that brings `sp` to 31 stores its value and sets `full`. If `cfg_rst_en` is high, `rst_req` is also 1 for exactly the cycle after that edge.
- R5: A push at `sp` = 31 writes nothing, leaves `sp` at 31 and keeps `full` set. It pulses `rst_req` only when `cfg_rst_en` is high.
- R6: A pop at `sp` = 0 sets `unf` and leaves `sp` at 0. During that cycle `ret_addr` reads 0. It pulses `rst_req` only when `cfg_rst_en` is high.
- R7: `full` and `unf` are kept through `rst_n` and never clear by themselves. `flag_clr[1]` clears `full` and `flag_clr[0]` clears `unf`. When a flag is set and cleared in the same cycle, the set wins.
- R8: `tos_sel` selects a byte of the top entry: 0 is bits 7:0, 1 is bits 15:8, and 2 is bits 20:16, zero-extended. `tos_rdata` shows the selected byte. A write with `tos_we` changes only that byte. At `sp` = 0, and for `tos_sel` = 3, reads return 0 and writes are ignored.
- R9: With `sp_we` high, `sp` takes `sp_wdata` on the next edge, and the flags stay unchanged.
- R10: At most one action happens per cycle, in this order of priority: pointer load, push, pop, byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| cfg_rst_en | input | 1 | Full and underflow conditions request a reset |
| call_push | input | 1 | Push for a call or interrupt entry |
| call_addr | input | 21 | Return address stored by a call push |
| ins_push | input | 1 | Instruction push strobe |
| pc_now | input | 21 | Program counter stored by an instruction push |
| ret_pop | input | 1 | Pop for a return |
| ins_pop | input | 1 | Instruction pop strobe |
| tos_sel | input | 2 | Byte select of the top entry |
| tos_we | input | 1 | Byte write strobe |
| tos_wdata | input | 8 | Byte write data |
| tos_rdata | output | 8 | Selected byte of the top entry |
| sp_we | input | 1 | Pointer load strobe |
| sp_wdata | input | 5 | Pointer load value |
| flag_clr | input | 2 | Clear full (bit 1) and underflow (bit 0) |
| sp | output | 5 | Stack pointer |
| full | output | 1 | Full flag |
| unf | output | 1 | Underflow flag |
| ret_addr | output | 21 | Top entry, or 0 at position 0 |
| rst_req | output | 1 | One-cycle device reset request |

## Verification
`ret_addr` and `tos_rdata` are combinational from the pointer and the storage, so they are due in the same cycle as the strobe. `sp`, `full`, `unf` and `rst_req` are registers that change on the first rising edge after a strobe. `rst_req` stays high for that single cycle only. The bench drives every stimulus on a falling edge and checks the combinational outputs shortly after, before the rising edge. It checks the registered outputs on the next falling edge and then removes the stimulus, so each strobe spans exactly one rising edge.

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              cfg_rst_en,
  input  logic              call_push,
  input  logic [ADDR_W-1:0] call_addr,
  input  logic              ins_push,
  input  logic [ADDR_W-1:0] pc_now,
  input  logic              ret_pop,
  input  logic              ins_pop,
  input  logic [1:0]        tos_sel,
  input  logic              tos_we,
  input  logic [7:0]        tos_wdata,
  output logic [7:0]        tos_rdata,
  input  logic              sp_we,
  input  logic [PTR_W-1:0]  sp_wdata,
  input  logic [1:0]        flag_clr,
  output logic [PTR_W-1:0]  sp,
  output logic              full,
  output logic              unf,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              rst_req
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int UP_W  = ADDR_W - 16;
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] mem [DEPTH];

  wire sys_rst_n = rst_n & por_n;
  wire at_top    = (sp == TOP);
  wire at_bot    = (sp == '0);
  wire [PTR_W-1:0] sp_inc = sp + 1'b1;

  wire do_push = !sp_we && (call_push || ins_push);
  wire do_pop  = !sp_we && !do_push && (ret_pop || ins_pop);
  wire do_tw   = !sp_we && !do_push && !do_pop && tos_we && (tos_sel != 2'd3) && !at_bot;
  wire hit_top = do_push && (at_top || sp_inc == TOP);
  wire hit_bot = do_pop && at_bot;

  wire [ADDR_W-1:0] push_val = call_push ? call_addr : pc_now;

  assign ret_addr = at_bot ? '0 : mem[sp];

  always_comb begin
    case (tos_sel)
      2'd0:    tos_rdata = ret_addr[7:0];
      2'd1:    tos_rdata = ret_addr[15:8];
      2'd2:    tos_rdata = 8'(ret_addr[ADDR_W-1:16]);
      default: tos_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      sp      <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= (hit_top || hit_bot) && cfg_rst_en;
      if (sp_we)
        sp <= sp_wdata;
      else if (do_push && !at_top)
        sp <= sp_inc;
      else if (do_pop && !at_bot)
        sp <= sp - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      full <= 1'b0;
      unf  <= 1'b0;
    end else begin
      if (flag_clr[1]) full <= 1'b0;
      if (flag_clr[0]) unf  <= 1'b0;
      if (rst_n && hit_top) full <= 1'b1;
      if (rst_n && hit_bot) unf  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (sys_rst_n && do_push && !at_top)
      mem[sp_inc] <= push_val;
    else if (sys_rst_n && do_tw) begin
      case (tos_sel)
        2'd0:    mem[sp][7:0]         <= tos_wdata;
        2'd1:    mem[sp][15:8]        <= tos_wdata;
        default: mem[sp][ADDR_W-1:16] <= tos_wdata[UP_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              cfg_rst_en,
  input logic              call_push,
  input logic              ins_push,
  input logic              ret_pop,
  input logic              ins_pop,
  input logic              sp_we,
  input logic [PTR_W-1:0]  sp_wdata,
  input logic [1:0]        flag_clr,
  input logic [PTR_W-1:0]  sp,
  input logic              full,
  input logic              unf,
  input logic [ADDR_W-1:0] ret_addr,
  input logic              rst_req
);
  localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};
  wire psh = !sp_we && (call_push || ins_push);
  wire pp  = !sp_we && !psh && (ret_pop || ins_pop);

  a_r9_sp_load: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
    sp_we |=> sp == $past(sp_wdata));

  a_r2_push_inc: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
    psh && sp != TOP |=> sp == PTR_W'($past(sp) + 1'b1));

  a_r3_pop_dec: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
    pp && sp != '0 |=> sp == PTR_W'($past(sp) - 1'b1));

  a_r4_full_req: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
    psh && cfg_rst_en && sp == TOP - 1'b1 |=> rst_req && full);

  a_r5_top_hold: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
    psh && sp == TOP |=> sp == TOP && $stable(ret_addr) && full);

  a_r6_underflow: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
    pp && sp == '0 |=> unf && sp == '0);

  a_r7_full_kept: assert property (@(posedge clk) disable iff (!por_n)
    full && !flag_clr[1] |=> full);

  a_r7_unf_kept: assert property (@(posedge clk) disable iff (!por_n)
    unf && !flag_clr[0] |=> unf);
endmodule

bind ras_stack ras_stack_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/ras_stack_test.sv
module ras_stack_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b1, cfg_rst_en = 1'b0;
  logic call_push = 0, ins_push = 0, ret_pop = 0, ins_pop = 0;
  logic [20:0] call_addr = '0, pc_now = '0;
  logic [1:0] tos_sel = '0, flag_clr = '0;
  logic tos_we = 0, sp_we = 0;
  logic [7:0] tos_wdata = '0;
  logic [4:0] sp_wdata = '0;
  logic [7:0] tos_rdata;
  logic [4:0] sp;
  logic full, unf, rst_req;
  logic [20:0] ret_addr;

  int n_chk = 0, n_fail = 0;
  int m_sp = 0;
  bit m_full = 0, m_unf = 0, m_req = 0;
  logic [20:0] m_mem [32];

  always #(CLK_P/2) clk = ~clk;

  ras_stack uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [20:0] m_tos();
    return (m_sp == 0) ? 21'd0 : m_mem[m_sp];
  endfunction

  function automatic logic [7:0] m_byte(input logic [1:0] s);
    logic [20:0] v = m_tos();
    case (s)
      2'd0: return v[7:0];
      2'd1: return v[15:8];
      2'd2: return {3'b000, v[20:16]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic clr_in();
    call_push = 0; ins_push = 0; ret_pop = 0; ins_pop = 0;
    tos_we = 0; sp_we = 0; flag_clr = '0;
  endtask

  task automatic model();
    m_req = 0;
    if (flag_clr[1]) m_full = 0;
    if (flag_clr[0]) m_unf = 0;
    if (sp_we) m_sp = int'(sp_wdata);
    else if (call_push || ins_push) begin
      if (m_sp == 31) begin
        m_full = 1; m_req = cfg_rst_en;
      end else begin
        m_sp++;
        m_mem[m_sp] = call_push ? call_addr : pc_now;
        if (m_sp == 31) begin m_full = 1; m_req = cfg_rst_en; end
      end
    end else if (ret_pop || ins_pop) begin
      if (m_sp == 0) begin m_unf = 1; m_req = cfg_rst_en; end
      else m_sp--;
    end else if (tos_we && m_sp != 0) begin
      case (tos_sel)
        2'd0: m_mem[m_sp][7:0] = tos_wdata;
        2'd1: m_mem[m_sp][15:8] = tos_wdata;
        2'd2: m_mem[m_sp][20:16] = tos_wdata[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic dev_rst();
    rst_n = 0; m_sp = 0;
    @(negedge clk);
    rst_n = 1;
    chk(sp == 0 && rst_req == 0, "R1", sp, 0);
    chk(full == m_full && unf == m_unf, "R7", {full, unf}, {m_full, m_unf});
  endtask

  task automatic step();
    #1;
    chk(ret_addr == m_tos(), "R3", ret_addr, m_tos());
    chk(tos_rdata == m_byte(tos_sel), "R8", tos_rdata, m_byte(tos_sel));
    model();
    @(negedge clk);
    clr_in();
    chk(sp == 5'(m_sp), "R2", sp, m_sp);
    chk(full == m_full, "R4", full, m_full);
    chk(unf == m_unf, "R6", unf, m_unf);
    chk(rst_req == m_req, "R5", rst_req, m_req);
    if (m_req) dev_rst();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    repeat (2) @(negedge clk);
    chk(sp == 0 && rst_req == 0 && full == 0 && unf == 0, "R1", {sp, full, unf, rst_req}, 0);
    por_n = 1;
    @(negedge clk);

    // R4 R5: fill to the top without reset request, then extra push ignored
    for (int i = 1; i <= 31; i++) begin
      if (i % 2) begin call_push = 1; call_addr = 21'(i * 40503 + 7); end
      else begin ins_push = 1; pc_now = 21'(i * 9001 + 3); end
      step();
    end
    chk(full == 1 && sp == 31, "R4", {full, sp}, {1'b1, 5'd31});
    ins_push = 1; pc_now = 21'h1ABCDE; step();
    chk(ret_addr == m_mem[31] && rst_req == 0, "R5", ret_addr, m_mem[31]);

    // R3 R6: unwind and underflow
    for (int i = 0; i < 31; i++) begin
      if (i % 2) ret_pop = 1; else ins_pop = 1;
      step();
    end
    ret_pop = 1; step();
    chk(unf == 1 && sp == 0 && ret_addr == 0, "R6", {unf, sp}, {1'b1, 5'd0});

    // R7: flags kept through device reset, cleared by write
    dev_rst();
    chk(unf == 1 && full == 1, "R7", {full, unf}, 2'b11);
    flag_clr = 2'b01; step();
    chk(unf == 0 && full == 1, "R7", {full, unf}, 2'b10);

    // R9 R4: load pointer, then reach the top with reset enabled
    cfg_rst_en = 1;
    sp_we = 1; sp_wdata = 5'd29; step();
    chk(sp == 29 && full == 1, "R9", sp, 29);
    flag_clr = 2'b10; step();
    call_push = 1; call_addr = 21'h0F0F0; step();
    call_push = 1; call_addr = 21'h15555; step();
    chk(full == 1 && sp == 0, "R4", {full, sp}, {1'b1, 5'd0});
    ins_pop = 1; step();
    chk(unf == 1, "R6", unf, 1);

    // R10: priority
    cfg_rst_en = 0;
    sp_we = 1; sp_wdata = 5'd12; call_push = 1; call_addr = 21'h11111; step();
    chk(sp == 12, "R10", sp, 12);
    ins_push = 1; pc_now = 21'h0BEEF; ret_pop = 1; step();
    chk(sp == 13 && ret_addr == 21'h0BEEF, "R10", ret_addr, 21'h0BEEF);
    call_push = 1; ins_push = 1; call_addr = 21'h12345; pc_now = 21'h054321; step();
    chk(ret_addr == 21'h12345, "R2", ret_addr, 21'h12345);

    // R8: byte access
    tos_we = 1; tos_sel = 2'd2; tos_wdata = 8'hFF; step();
    tos_sel = 2'd2; #1;
    chk(tos_rdata == 8'h1F && ret_addr == 21'h1F2345, "R8", ret_addr, 21'h1F2345);
    tos_we = 1; tos_sel = 2'd3; tos_wdata = 8'hAA; step();
    chk(ret_addr == 21'h1F2345, "R8", ret_addr, 21'h1F2345);
    sp_we = 1; sp_wdata = 5'd0; step();
    tos_we = 1; tos_sel = 2'd0; tos_wdata = 8'h5A; step();
    chk(ret_addr == 0 && tos_rdata == 0, "R8", ret_addr, 0);
    sp_we = 1; sp_wdata = 5'd14; step();

    // R1: power-on reset clears flags
    por_n = 0; m_sp = 0; m_full = 0; m_unf = 0;
    @(negedge clk);
    por_n = 1;
    chk(full == 0 && unf == 0 && sp == 0, "R1", {full, unf, sp}, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      if (i % 300 == 0) cfg_rst_en = 1'($urandom);
      r = int'($urandom % 100);
      if (r < 55) begin
        if ($urandom % 2) begin call_push = 1; call_addr = 21'($urandom); end
        else begin ins_push = 1; pc_now = 21'($urandom); end
      end else if (r < 75) begin
        if ($urandom % 2) ret_pop = 1; else ins_pop = 1;
      end else if (r < 88) begin
        tos_we = 1; tos_wdata = 8'($urandom);
      end else if (r < 93) begin
        sp_we = 1; sp_wdata = 5'($urandom);
      end else if (r < 96) begin
        flag_clr = 2'($urandom);
      end
      tos_sel = 2'($urandom);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule